// File: doc/BRIEF.md
# Trigger-Indexed Hit Buffer

This block holds pixel hit words in a banked storage array whose address comes from the hit itself and not from the order in which hits arrive. The hit's time stamp picks a word line, the pixel row picks one of sixteen banks, and the pixel column picks one cell of that word. Each cell keeps an occupancy flag and a 3-bit pulse height. Hits are expected in time order. The first hit carrying a new time stamp wipes that word line in every bank before it is stored, so a line is cleaned out when the 8-bit time stamp wraps around and the line is used again.

A level-1 trigger carries the time at which it was issued. A latency offset, given in time-stamp units, is subtracted from that time to get a centre word line. The block then scans the line before the centre, the centre and the line after it, all modulo 256, so that trigger jitter is tolerated. Every occupied cell found on those lines is streamed out, one record per cycle, and cleared. A done pulse closes each trigger's readout. Triggers that arrive while a scan is running wait in a small queue. A trigger that finds the queue full is dropped and raises a sticky flag.

Top module: `trig_hit_buffer`

## Requirements
- R1: After reset, outValid, outDone and trigOverflow are low, and no word line holds an occupied cell.
- R2: A hit with valid high is stored at word line hitTs, bank hitRow and cell hitCol. Its readout record reports the same time stamp, row, column and 3-bit pulse height.
- R3: For a trigger, the centre line is (trigTs - latencyOffset) mod 256. Only lines centre-1, centre and centre+1 (mod 256) are read. A hit on any other line is not emitted.
- R4: Records come out one per cycle. The line order is centre-1, then centre, then centre+1. Within a line the banks go from 0 to 15, and within a bank the columns go in ascending order.
- R5: Only occupied cells are emitted. An emitted cell is cleared, so a second trigger on the same lines emits nothing.
- R6: A hit whose time stamp differs from the previous hit's time stamp first clears every cell of its word line in all banks.
- R7: outDone is high for exactly one cycle per serviced trigger. It comes after that trigger's last record and never in the same cycle as outValid.
- R8: Triggers that arrive during a scan are queued. Up to 4 can wait at once, and they are serviced in arrival order.
- R9: A trigger that arrives while 4 triggers are waiting is dropped and sets trigOverflow. The flag stays high until reset.
- R10: A second hit to the same cell with the same time stamp replaces the stored pulse height, and the cell is emitted only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| latencyOffset | input | 8 | Trigger latency in time-stamp units |
| hitValid | input | 1 | Hit strobe |
| hitTs | input | 8 | Hit time stamp (word line) |
| hitRow | input | 4 | Pixel row (bank) |
| hitCol | input | 5 | Pixel column (cell in word) |
| hitPh | input | 3 | Pulse height |
| trigValid | input | 1 | Trigger strobe |
| trigTs | input | 8 | Trigger time stamp |
| outValid | output | 1 | Readout record valid |
| outTs | output | 8 | Record word line |
| outRow | output | 4 | Record pixel row |
| outCol | output | 5 | Record pixel column |
| outPh | output | 3 | Record pulse height |
| outDone | output | 1 | End of one trigger's readout |
| trigOverflow | output | 1 | Sticky trigger queue overflow |

## Verification
The bench keeps a list of the live hits and works out, for every trigger, the exact ordered record stream. It compares the design's stream record by record. It covers a window that wraps from line 255 to line 0 and a latency subtraction that borrows below zero; a design that misses either case would read the wrong lines. A return to an older time stamp must erase that line. A design that skips the wipe would replay stale hits, and one that wipes on every hit would lose hits that share a line. The queue is filled to exactly four waiting triggers and then pushed one past that. A design with an off-by-one depth would either raise the flag too early or drop a trigger silently. The number of done pulses and the place of the one hit-bearing trigger in the queue show whether the order is kept.

// File: rtl/thb_pkg.sv
package thb_pkg;
  localparam int TS_W      = 8;
  localparam int ROW_W     = 4;
  localparam int COL_W     = 5;
  localparam int PH_W      = 3;
  localparam int NUM_LINES = 1 << TS_W;
  localparam int NUM_BANKS = 1 << ROW_W;
  localparam int NUM_COLS  = 1 << COL_W;
  localparam int WINDOW    = 3;

  typedef struct packed {
    logic             clrEn;
    logic [TS_W-1:0]  line;
    logic [ROW_W-1:0] bank;
    logic [COL_W-1:0] col;
  } scanStrobe_t;
endpackage

// File: rtl/thb_bank.sv
module thb_bank
  import thb_pkg::*;
(
  input  logic                     clk,
  input  logic                     wipeEn,
  input  logic                     wrSel,
  input  logic [TS_W-1:0]          wrLine,
  input  logic [COL_W-1:0]         wrCol,
  input  logic [PH_W-1:0]          wrPh,
  input  logic                     clrEn,
  input  logic [TS_W-1:0]          clrLine,
  input  logic [COL_W-1:0]         clrCol,
  input  logic [TS_W-1:0]          rdLine,
  output logic [NUM_COLS-1:0]      rdOcc,
  output logic [NUM_COLS*PH_W-1:0] rdPh
);
  logic [NUM_COLS-1:0]      occMem [NUM_LINES];
  logic [NUM_COLS*PH_W-1:0] phMem  [NUM_LINES];
  logic [NUM_COLS-1:0]      colOneHot;

  assign colOneHot = NUM_COLS'(1) << wrCol;

  // Clear first so a write to the same word in the same cycle takes effect.
  always_ff @(posedge clk) begin
    if (clrEn) occMem[clrLine][clrCol] <= 1'b0;
    if (wipeEn) occMem[wrLine] <= wrSel ? colOneHot : '0;
    else if (wrSel) occMem[wrLine][wrCol] <= 1'b1;
    if (wrSel) phMem[wrLine][wrCol*PH_W +: PH_W] <= wrPh;
  end

  assign rdOcc = occMem[rdLine];
  assign rdPh  = phMem[rdLine];
endmodule

// File: rtl/thb_datapath.sv
module thb_datapath
  import thb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hitValid,
  input  logic [TS_W-1:0]   hitTs,
  input  logic [ROW_W-1:0]  hitRow,
  input  logic [COL_W-1:0]  hitCol,
  input  logic [PH_W-1:0]   hitPh,
  input  scanStrobe_t       strobe,
  output logic              wordAny,
  output logic [COL_W-1:0]  firstCol,
  output logic [PH_W-1:0]   firstPh
);
  logic [TS_W-1:0]          lastTs;
  logic                     lastValid;
  logic [NUM_LINES-1:0]     lineValid;
  logic                     wipeEn;
  logic [NUM_COLS-1:0]      bankOcc [NUM_BANKS];
  logic [NUM_COLS*PH_W-1:0] bankPh  [NUM_BANKS];
  logic [NUM_COLS-1:0]      readOcc;
  logic [NUM_COLS*PH_W-1:0] readPh;

  assign wipeEn = hitValid && (!lastValid || hitTs != lastTs);

  always_ff @(posedge clk) begin
    if (rst) begin
      lastTs    <= '0;
      lastValid <= 1'b0;
      lineValid <= '0;
    end else if (hitValid) begin
      lastTs    <= hitTs;
      lastValid <= 1'b1;
      if (wipeEn) lineValid[hitTs] <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    thb_bank u_bank (
      .clk     (clk),
      .wipeEn  (wipeEn),
      .wrSel   (hitValid && hitRow == ROW_W'(b)),
      .wrLine  (hitTs),
      .wrCol   (hitCol),
      .wrPh    (hitPh),
      .clrEn   (strobe.clrEn && strobe.bank == ROW_W'(b)),
      .clrLine (strobe.line),
      .clrCol  (strobe.col),
      .rdLine  (strobe.line),
      .rdOcc   (bankOcc[b]),
      .rdPh    (bankPh[b])
    );
  end

  assign readOcc = bankOcc[strobe.bank] & {NUM_COLS{lineValid[strobe.line]}};
  assign readPh  = bankPh[strobe.bank];

  always_comb begin
    firstCol = '0;
    for (int i = NUM_COLS - 1; i >= 0; i--) begin
      if (readOcc[i]) firstCol = COL_W'(i);
    end
  end

  assign wordAny = |readOcc;
  assign firstPh = readPh[firstCol*PH_W +: PH_W];
endmodule

// File: rtl/thb_ctrl.sv
module thb_ctrl
  import thb_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigValid,
  input  logic [TS_W-1:0]   trigTs,
  input  logic [TS_W-1:0]   latencyOffset,
  input  logic              wordAny,
  input  logic [COL_W-1:0]  firstCol,
  input  logic [PH_W-1:0]   firstPh,
  output scanStrobe_t       strobe,
  output logic              outValid,
  output logic [TS_W-1:0]   outTs,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic [PH_W-1:0]   outPh,
  output logic              outDone,
  output logic              trigOverflow
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PH_CNT_W = $clog2(WINDOW);

  typedef enum logic {ST_IDLE, ST_SCAN} state_t;

  state_t               state;
  logic [TS_W-1:0]      fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]     rdPtr, wrPtr;
  logic [CNT_W-1:0]     count;
  logic                 push, pop, full;
  logic [TS_W-1:0]      scanLine;
  logic [ROW_W-1:0]     scanBank;
  logic [PH_CNT_W-1:0]  phase;
  logic [TS_W-1:0]      centreLine;

  assign full       = count == CNT_W'(FIFO_DEPTH);
  assign push       = trigValid && !full;
  assign pop        = state == ST_IDLE && count != '0;
  assign centreLine = fifoMem[rdPtr] - latencyOffset;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr        <= '0;
      wrPtr        <= '0;
      count        <= '0;
      trigOverflow <= 1'b0;
    end else begin
      if (push) begin
        fifoMem[wrPtr] <= trigTs;
        wrPtr          <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (trigValid && full) trigOverflow <= 1'b1;
    end
  end

  always_comb begin
    strobe.clrEn = state == ST_SCAN && wordAny;
    strobe.line  = scanLine;
    strobe.bank  = scanBank;
    strobe.col   = firstCol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scanLine <= '0;
      scanBank <= '0;
      phase    <= '0;
      outValid <= 1'b0;
      outDone  <= 1'b0;
      outTs    <= '0;
      outRow   <= '0;
      outCol   <= '0;
      outPh    <= '0;
    end else begin
      outValid <= 1'b0;
      outDone  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pop) begin
            scanLine <= centreLine - 1'b1;
            scanBank <= '0;
            phase    <= '0;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (wordAny) begin
            outValid <= 1'b1;
            outTs    <= scanLine;
            outRow   <= scanBank;
            outCol   <= firstCol;
            outPh    <= firstPh;
          end else begin
            scanBank <= scanBank + 1'b1;
            if (scanBank == ROW_W'(NUM_BANKS - 1)) begin
              if (phase == PH_CNT_W'(WINDOW - 1)) begin
                state   <= ST_IDLE;
                outDone <= 1'b1;
              end else begin
                phase    <= phase + 1'b1;
                scanLine <= scanLine + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_hit_buffer.sv
module trig_hit_buffer
  import thb_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   latencyOffset,
  input  logic              hitValid,
  input  logic [TS_W-1:0]   hitTs,
  input  logic [ROW_W-1:0]  hitRow,
  input  logic [COL_W-1:0]  hitCol,
  input  logic [PH_W-1:0]   hitPh,
  input  logic              trigValid,
  input  logic [TS_W-1:0]   trigTs,
  output logic              outValid,
  output logic [TS_W-1:0]   outTs,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic [PH_W-1:0]   outPh,
  output logic              outDone,
  output logic              trigOverflow
);
  scanStrobe_t      strobe;
  logic             wordAny;
  logic [COL_W-1:0] firstCol;
  logic [PH_W-1:0]  firstPh;

  thb_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .hitValid (hitValid),
    .hitTs    (hitTs),
    .hitRow   (hitRow),
    .hitCol   (hitCol),
    .hitPh    (hitPh),
    .strobe   (strobe),
    .wordAny  (wordAny),
    .firstCol (firstCol),
    .firstPh  (firstPh)
  );

  thb_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .trigValid     (trigValid),
    .trigTs        (trigTs),
    .latencyOffset (latencyOffset),
    .wordAny       (wordAny),
    .firstCol      (firstCol),
    .firstPh       (firstPh),
    .strobe        (strobe),
    .outValid      (outValid),
    .outTs         (outTs),
    .outRow        (outRow),
    .outCol        (outCol),
    .outPh         (outPh),
    .outDone       (outDone),
    .trigOverflow  (trigOverflow)
  );
endmodule

// File: rtl/trig_hit_buffer_checker.sv
module trig_hit_buffer_checker
  import thb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             trigValid,
  input logic             outValid,
  input logic [TS_W-1:0]  outTs,
  input logic [ROW_W-1:0] outRow,
  input logic [COL_W-1:0] outCol,
  input logic             outDone,
  input logic             trigOverflow
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && !outDone && !trigOverflow));

  assert_column_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(outValid) && outTs == $past(outTs) && outRow == $past(outRow))
      |-> (outCol > $past(outCol)));

  assert_done_apart_R7: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outDone));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    outDone |=> !outDone);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    trigOverflow |=> trigOverflow);

  assert_overflow_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(trigOverflow) |-> $past(trigValid));
endmodule

bind trig_hit_buffer trig_hit_buffer_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .trigValid    (trigValid),
  .outValid     (outValid),
  .outTs        (outTs),
  .outRow       (outRow),
  .outCol       (outCol),
  .outDone      (outDone),
  .trigOverflow (trigOverflow)
);

// File: tb/trig_hit_buffer_test.sv
module trig_hit_buffer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] latencyOffset = 8'd0;
  logic       hitValid = 1'b0;
  logic [7:0] hitTs = '0;
  logic [3:0] hitRow = '0;
  logic [4:0] hitCol = '0;
  logic [2:0] hitPh = '0;
  logic       trigValid = 1'b0;
  logic [7:0] trigTs = '0;
  logic       outValid;
  logic [7:0] outTs;
  logic [3:0] outRow;
  logic [4:0] outCol;
  logic [2:0] outPh;
  logic       outDone;
  logic       trigOverflow;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  trig_hit_buffer uut (
    .clk(clk), .rst(rst), .latencyOffset(latencyOffset),
    .hitValid(hitValid), .hitTs(hitTs), .hitRow(hitRow), .hitCol(hitCol), .hitPh(hitPh),
    .trigValid(trigValid), .trigTs(trigTs),
    .outValid(outValid), .outTs(outTs), .outRow(outRow), .outCol(outCol), .outPh(outPh),
    .outDone(outDone), .trigOverflow(trigOverflow)
  );

  // Shadow list of stored hits
  int mTs[64], mRow[64], mCol[64], mPh[64];
  bit mAlive[64];
  int mCount = 0;
  int lastTs = -1;

  // Expected record stream of one trigger
  int eTs[64], eRow[64], eCol[64], ePh[64], eIdx[64];
  int eCount;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compactModel();
    int k = 0;
    for (int i = 0; i < mCount; i++) begin
      if (mAlive[i]) begin
        mTs[k] = mTs[i]; mRow[k] = mRow[i]; mCol[k] = mCol[i]; mPh[k] = mPh[i];
        mAlive[k] = 1'b1;
        k++;
      end
    end
    mCount = k;
  endtask

  task automatic writeHit(input int ts, input int row, input int col, input int ph);
    if (ts != lastTs) begin
      for (int i = 0; i < mCount; i++) if (mTs[i] == ts) mAlive[i] = 1'b0;
    end
    for (int i = 0; i < mCount; i++)
      if (mTs[i] == ts && mRow[i] == row && mCol[i] == col) mAlive[i] = 1'b0;
    if (mCount == 64) compactModel();
    mTs[mCount] = ts; mRow[mCount] = row; mCol[mCount] = col; mPh[mCount] = ph;
    mAlive[mCount] = 1'b1;
    mCount++;
    lastTs = ts;
    @(negedge clk);
    hitValid = 1'b1; hitTs = 8'(ts); hitRow = 4'(row); hitCol = 5'(col); hitPh = 3'(ph);
    @(negedge clk);
    hitValid = 1'b0;
  endtask

  task automatic buildExpected(input int tts);
    int centre = (tts - int'(latencyOffset)) & 255;
    eCount = 0;
    for (int p = 0; p < 3; p++) begin
      int line = (centre - 1 + p) & 255;
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 32; c++)
          for (int i = 0; i < mCount; i++)
            if (mAlive[i] && mTs[i] == line && mRow[i] == b && mCol[i] == c) begin
              eTs[eCount] = line; eRow[eCount] = b; eCol[eCount] = c;
              ePh[eCount] = mPh[i]; eIdx[eCount] = i;
              eCount++;
            end
    end
  endtask

  task automatic pulseTrigger(input int tts);
    @(negedge clk);
    trigValid = 1'b1; trigTs = 8'(tts);
    @(negedge clk);
    trigValid = 1'b0;
  endtask

  // Issue one trigger on an idle design and compare the whole record stream.
  task automatic runTrigger(input int tts, input string req);
    int got = 0;
    bit done = 1'b0;
    buildExpected(tts);
    pulseTrigger(tts);
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      if (outValid) begin
        if (got < eCount) begin
          check(outTs == 8'(eTs[got]), req, "record ts", outTs, eTs[got]);
          check(outRow == 4'(eRow[got]), req, "record row", outRow, eRow[got]);
          check(outCol == 5'(eCol[got]), req, "record col", outCol, eCol[got]);
          check(outPh == 3'(ePh[got]), req, "record ph", outPh, ePh[got]);
        end
        got++;
      end
      if (outDone) done = 1'b1;
      @(negedge clk);
    end
    check(done, "R7", "done seen", int'(done), 1);
    check(got == eCount, req, "record count", got, eCount);
    for (int k = 0; k < eCount; k++) mAlive[eIdx[k]] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int dones, recAt, doneBefore;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!outValid, "R1", "outValid after reset", outValid, 0);
    check(!outDone, "R1", "outDone after reset", outDone, 0);
    check(!trigOverflow, "R1", "overflow after reset", trigOverflow, 0);
    latencyOffset = 8'd50;
    runTrigger(60, "R1");

    // R2 R3 R4: centre line 10, hits on lines 8..12
    writeHit(8, 2, 3, 1);
    writeHit(9, 3, 4, 2);
    writeHit(10, 5, 20, 3);
    writeHit(10, 5, 2, 4);
    writeHit(10, 0, 31, 5);
    writeHit(10, 15, 0, 6);
    writeHit(11, 1, 31, 7);
    writeHit(12, 2, 0, 1);
    runTrigger(60, "R3");
    // R5: read cells are cleared
    runTrigger(60, "R5");

    // R3 wrap of the window across line 0
    writeHit(254, 1, 1, 1);
    writeHit(255, 7, 9, 2);
    writeHit(0, 7, 8, 3);
    writeHit(1, 0, 0, 4);
    writeHit(2, 4, 4, 5);
    runTrigger(50, "R3");

    // R3 borrow in the latency subtraction: centre 211
    writeHit(209, 3, 3, 1);
    writeHit(210, 9, 17, 2);
    writeHit(211, 12, 5, 3);
    writeHit(212, 6, 30, 4);
    writeHit(213, 6, 29, 5);
    runTrigger(5, "R3");

    // R6 wipe on time stamp change, R10 rewrite of a cell
    latencyOffset = 8'd0;
    writeHit(30, 4, 7, 1);
    writeHit(30, 8, 8, 2);
    writeHit(31, 2, 2, 3);
    writeHit(30, 6, 1, 2);
    writeHit(30, 6, 1, 5);
    runTrigger(31, "R6");
    runTrigger(31, "R10");

    // R2 R4 sweep: every bank, two columns each, one line
    for (int r = 0; r < 16; r++) begin
      writeHit(70, r, (r * 7 + 13) % 32, (r + 1) % 8);
      writeHit(70, r, (r * 7) % 32, r % 8);
    end
    runTrigger(71, "R4");

    // R8 R9 queue depth and overflow
    writeHit(121, 0, 0, 6);
    pulseTrigger(100);
    repeat (5) @(negedge clk);
    trigValid = 1'b1; trigTs = 8'd121;
    @(negedge clk);
    trigTs = 8'd100;
    repeat (3) @(negedge clk);
    trigValid = 1'b0;
    check(!trigOverflow, "R8", "no overflow at 4 waiting", trigOverflow, 0);
    pulseTrigger(100);
    check(trigOverflow, "R9", "overflow on 5th waiting", trigOverflow, 1);
    dones = 0; recAt = -1; doneBefore = 0;
    for (int cyc = 0; cyc < 1200; cyc++) begin
      if (outValid) begin
        recAt = dones;
        check(outTs == 8'd121 && outCol == 5'd0 && outPh == 3'd6, "R8", "queued record",
              outTs, 121);
      end
      if (outDone) dones++;
      @(negedge clk);
    end
    doneBefore = recAt;
    check(dones == 5, "R8", "done count", dones, 5);
    check(doneBefore == 1, "R8", "service order", doneBefore, 1);
    check(trigOverflow, "R9", "overflow sticky", trigOverflow, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule